// File: doc/BRIEF.md
# Digital First-Order Delta-Sigma Bitstream Generator

This block produces a one-bit density stream from an unsigned level code, one new bit on every clock, the way a first-order delta-sigma converter does. A counter elsewhere counts the ones over a chosen number of clocks, and that count is the converted sample. Counting over 256 clocks gives roughly 8 bits of resolution, and longer windows give more.

The code does not map onto the full 0..1 density range. It is squeezed into a window from 1/8 to 7/8, so that a measurement can still resolve levels a little below ground and a little above supply. A calibration selector can replace the code with an exact ground level (1/8 density) or an exact supply level (7/8 density). Software can then read the two endpoints it actually gets and scale its samples to match.

The core is a phase accumulator as wide as the code. Each clock it adds the mapped level, and the carry out becomes the output bit.

Top module: `dsm_modulator`

## Requirements
- R1: While `rst_n_i` is low, `bit_o` is 0. Reset release takes effect on the third rising clock edge after `rst_n_i` rises. At that point the accumulator holds 128, so a code of 128 with enable high gives the bits 1,0,1,0,… from that edge on.
- R2: On any clock edge where `en_i` is low, `bit_o` becomes 0 and the accumulator is cleared to 0, whatever the code and calibration inputs are. After enable returns with code 128, the bits are 0,1,0,1,….
- R3: On each enabled edge the design forms sum = accumulator + mapped level. `bit_o` becomes 1 exactly when sum ≥ 256, and the accumulator becomes sum mod 256.
- R4: The mapped level for a code c is 32 + floor(3·c/4). Code 0 maps to 32, code 128 to 128, and code 255 to 223.
- R5: With `cal_sel_i` = 2'b01 (ground), the mapped level is 32 and the code is ignored. After the first 1, the stream has exactly one 1 in every 8 clocks.
- R6: With `cal_sel_i` = 2'b10 (supply), the mapped level is 224 and the code is ignored. The stream has exactly seven 1s in every 8 clocks.
- R7: A code of 128 in normal mode gives a strictly alternating stream.
- R8: Over any 256 consecutive enabled clocks with a steady input, the number of 1s equals the mapped level.
- R9: `cal_sel_i` = 2'b00 and 2'b11 both select the code path.
- R10: While enabled, `bit_o` never shows more than 7 equal bits in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one output bit per rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Run enable; low clears the accumulator and forces the output to 0 |
| code_i | input | 8 | Unsigned level code; 0 is ground and 255 is supply |
| cal_sel_i | input | 2 | Level source: 00 or 11 code, 01 ground, 10 supply |
| bit_o | output | 1 | Registered density bit |

## Verification
A wrong accumulator value or a wrong carry appears on `bit_o` as a changed bit within at most eight clocks. The accumulator is cleared or refilled by every enabled run, so the bench compares every cycle against an independent reference model and catches such a slip on the cycle it appears. A mapping error leaves the early bits looking plausible but changes the count over a 256-clock window by at least one. The bench therefore also counts complete windows for several codes and for both calibration levels. Reset and enable faults show up within the first three bits after release or re-enable.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  // Level-source select encoding
  typedef enum logic [1:0] {
    CAL_CODE  = 2'b00,
    CAL_GND   = 2'b01,
    CAL_SUP   = 2'b10,
    CAL_CODE2 = 2'b11
  } cal_sel_e;

endpackage

// File: rtl/dsm_reset_sync.sv
module dsm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/dsm_level_map.sv
// Compresses a code into the 1/8 .. 7/8 density window: OFFSET + floor(3*c/4).
module dsm_level_map #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] level_o
);

  localparam int FULL   = 1 << CODE_W;
  localparam int OFFSET = FULL / 8;

  logic [CODE_W+1:0] triple;
  logic [CODE_W-1:0] scaled;

  always_comb begin
    triple  = {2'b00, code_i} + {1'b0, code_i, 1'b0};
    scaled  = triple[CODE_W+1:2];
    level_o = scaled + CODE_W'(OFFSET);
  end

endmodule

// File: rtl/dsm_cal_mux.sv
module dsm_cal_mux #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] level_i,
  input  logic [1:0]        cal_i,
  output logic [CODE_W-1:0] level_o
);
  import dsm_pkg::*;

  localparam int FULL      = 1 << CODE_W;
  localparam int GND_LEVEL = FULL / 8;
  localparam int SUP_LEVEL = FULL - GND_LEVEL;

  cal_sel_e sel;

  always_comb begin
    sel = cal_sel_e'(cal_i);
    case (sel)
      CAL_GND: level_o = CODE_W'(GND_LEVEL);
      CAL_SUP: level_o = CODE_W'(SUP_LEVEL);
      default: level_o = level_i;
    endcase
  end

endmodule

// File: rtl/dsm_accum.sv
// First-order error accumulator: the carry out is the density bit.
module dsm_accum #(
  parameter int CODE_W    = 8,
  parameter int RESET_ACC = 128
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] level_i,
  output logic              bit_o
);

  logic [CODE_W-1:0] acc_q, acc_d;
  logic              bit_q, bit_d;
  logic [CODE_W:0]   sum;

  always_comb begin
    sum = {1'b0, acc_q} + {1'b0, level_i};
    if (en_i) begin
      acc_d = sum[CODE_W-1:0];
      bit_d = sum[CODE_W];
    end else begin
      acc_d = '0;
      bit_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      acc_q <= CODE_W'(RESET_ACC);
      bit_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      bit_q <= bit_d;
    end
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/dsm_modulator.sv
module dsm_modulator #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        cal_sel_i,
  output logic              bit_o
);

  localparam int FULL      = 1 << CODE_W;
  localparam int RESET_ACC = FULL / 2;

  logic              core_rst_n;
  logic [CODE_W-1:0] mapped_level;
  logic [CODE_W-1:0] chosen_level;

  dsm_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (core_rst_n)
  );

  dsm_level_map #(.CODE_W(CODE_W)) u_map (
    .code_i  (code_i),
    .level_o (mapped_level)
  );

  dsm_cal_mux #(.CODE_W(CODE_W)) u_cal (
    .level_i (mapped_level),
    .cal_i   (cal_sel_i),
    .level_o (chosen_level)
  );

  dsm_accum #(.CODE_W(CODE_W), .RESET_ACC(RESET_ACC)) u_acc (
    .clk_i   (clk_i),
    .rst_n_i (core_rst_n),
    .en_i    (en_i),
    .level_i (chosen_level),
    .bit_o   (bit_o)
  );

endmodule

// File: rtl/dsm_modulator_chk.sv
module dsm_modulator_chk (
  input logic       clk_i,
  input logic       rst_n_i,
  input logic       en_i,
  input logic [1:0] cal_sel_i,
  input logic       bit_o
);
  import dsm_pkg::*;

  logic       en_q;
  logic [3:0] zero_run_q, one_run_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      en_q       <= 1'b0;
      zero_run_q <= '0;
      one_run_q  <= '0;
    end else begin
      en_q       <= en_i;
      zero_run_q <= (en_q && !bit_o && zero_run_q != 4'hF) ? zero_run_q + 4'd1 : 4'd0;
      one_run_q  <= (en_q &&  bit_o && one_run_q  != 4'hF) ? one_run_q  + 4'd1 : 4'd0;
    end
  end

  // R2: a disabled edge forces the output low
  a_r2_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !en_i |=> !bit_o);

  // R10: bounded runs of equal bits while enabled
  a_r10_zero_run: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    zero_run_q <= 4'd7);
  a_r10_one_run: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    one_run_q <= 4'd7);

  // R5: at ground level a 1 is always followed by a 0
  a_r5_gnd_sparse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (en_i && cal_sel_i == CAL_GND && $past(en_i && cal_sel_i == CAL_GND) && bit_o)
    |=> !bit_o);

  // R6: at supply level a 0 is always followed by a 1
  a_r6_sup_dense: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (en_i && cal_sel_i == CAL_SUP && $past(en_i && cal_sel_i == CAL_SUP) && !bit_o)
    |=> bit_o);

endmodule

bind dsm_modulator dsm_modulator_chk u_chk (
  .clk_i     (clk_i),
  .rst_n_i   (rst_n_i),
  .en_i      (en_i),
  .cal_sel_i (cal_sel_i),
  .bit_o     (bit_o)
);

// File: tb/dsm_modulator_tb.sv
module dsm_modulator_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [7:0] code;
  logic [1:0] cal;
  logic       bit_w;

  int checks = 0;
  int errors = 0;
  bit live   = 0;
  bit done   = 0;

  // reference model state
  int m_sync = 0;
  int m_acc  = 128;
  int m_bit  = 0;
  int zrun   = 0;
  int orun   = 0;
  bit en_prev = 0;

  always #5 clk = ~clk;

  dsm_modulator u_dut (
    .clk_i     (clk),
    .rst_n_i   (rst_n),
    .en_i      (en),
    .code_i    (code),
    .cal_sel_i (cal),
    .bit_o     (bit_w)
  );

  function automatic int level_of(input int c, input int s);
    if (s == 1) return 32;
    if (s == 2) return 224;
    return 32 + (c * 3) / 4;
  endfunction

  always @(posedge clk) begin
    en_prev <= en;
    if (!rst_n) begin
      m_sync = 0; m_acc = 128; m_bit = 0;
    end else if (m_sync < 2) begin
      m_sync++; m_acc = 128; m_bit = 0;
    end else if (!en) begin
      m_acc = 0; m_bit = 0;
    end else begin
      int s;
      s = m_acc + level_of(code, cal);
      m_bit = (s >= 256) ? 1 : 0;
      m_acc = s % 256;
    end
  end

  task automatic fail(input string req, input int act, input int exp);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
  endtask

  // R3: per-clock comparison with the model; R10: run lengths
  always @(negedge clk) begin
    if (live && !done) begin
      checks++;
      if (int'(bit_w) != m_bit) fail("R3", bit_w, m_bit);
      if (en_prev && rst_n) begin
        if (bit_w) begin orun++; zrun = 0; end else begin zrun++; orun = 0; end
        if (zrun > 7 || orun > 7) begin
          checks++;
          fail("R10", (zrun > orun) ? zrun : orun, 7);
          zrun = 0; orun = 0;
        end
      end else begin
        zrun = 0; orun = 0;
      end
    end
  end

  task automatic step(output int b);
    @(negedge clk);
    b = bit_w;
  endtask

  task automatic count_ones(input int n, output int ones);
    int b;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      step(b);
      ones += b;
    end
  endtask

  task automatic expect_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) fail(req, act, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b, n;
    rst_n = 1'b0; en = 1'b1; code = 8'd128; cal = 2'b00;
    repeat (4) @(negedge clk);
    expect_eq("R1 reset output", bit_w, 0);
    live = 1;
    rst_n = 1'b1;
    // R1: two held edges, then 1,0,1,0
    step(b); expect_eq("R1 hold1", b, 0);
    step(b); expect_eq("R1 hold2", b, 0);
    step(b); expect_eq("R1 bit1", b, 1);
    step(b); expect_eq("R1 bit2", b, 0);
    step(b); expect_eq("R1 bit3", b, 1);
    step(b); expect_eq("R1 bit4", b, 0);
    // R7: alternation holds over a long stretch
    begin
      int prev, bad;
      prev = b; bad = 0;
      for (int i = 0; i < 64; i++) begin
        step(b);
        if (b == prev) bad++;
        prev = b;
      end
      expect_eq("R7 alternation breaks", bad, 0);
    end
    // R2: disabled output stays 0 whatever the inputs
    en = 1'b0; code = 8'd255; cal = 2'b10;
    step(b); expect_eq("R2 disable", b, 0);
    count_ones(20, n); expect_eq("R2 disabled ones", n, 0);
    code = 8'd128; cal = 2'b00; en = 1'b1;
    step(b); expect_eq("R2 restart bit1", b, 0);
    step(b); expect_eq("R2 restart bit2", b, 1);
    step(b); expect_eq("R2 restart bit3", b, 0);
    // R8/R4: window counts for several codes
    foreach (code_list[i]) begin
      code = code_list[i];
      count_ones(256, n);
      expect_eq($sformatf("R8 R4 code %0d", code_list[i]), n, 32 + (code_list[i] * 3) / 4);
    end
    // R5: ground calibration ignores the code
    cal = 2'b01; code = 8'd200;
    count_ones(8, n);
    count_ones(64, n); expect_eq("R5 ground density", n, 8);
    code = 8'd3;
    count_ones(256, n); expect_eq("R5 ground window", n, 32);
    // R6: supply calibration
    cal = 2'b10; code = 8'd7;
    count_ones(8, n);
    count_ones(64, n); expect_eq("R6 supply density", n, 56);
    count_ones(256, n); expect_eq("R6 supply window", n, 224);
    // R9: select 11 behaves like the code path
    cal = 2'b11; code = 8'd77;
    count_ones(256, n); expect_eq("R9 alt select", n, 32 + (77 * 3) / 4);
    cal = 2'b00; code = 8'd255;
    count_ones(256, n); expect_eq("R9 R4 top code", n, 223);
    // R1: reset in mid-run returns output to 0
    rst_n = 1'b0;
    #1; expect_eq("R1 async reset", bit_w, 0);
    @(negedge clk); rst_n = 1'b1;
    count_ones(40, n);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int code_list[5] = '{0, 13, 77, 128, 255};

endmodule